// File: doc/BRIEF.md
# Broadcast FIFO with Per-Reader Pointers

This block is a first-in first-out store with one writer and several readers. It sits in the writer's local memory. The writer adds words through a push port. Each reader takes words at its own pace through its own pull port, and each reader sees every word in push order. There is one write pointer and one read pointer per reader. A storage slot comes back into use only after every enabled reader has taken the word in it, so the slowest enabled reader sets how much room is left.

Each reader port shows a count of words it has not yet read. The count works like a semaphore: a pushed word adds one and a pull takes one away. An enable mask chooses which readers take part. A reader can be dropped at any time, and it then stops holding storage. A reader can be added only while no enabled reader has unread words. A push into a full store is dropped and sets a sticky overflow flag. A pull from an empty reader view sets that reader's sticky underflow flag.

Top module: `mcast_fifo`

## Requirements
- R1: After reset every reader count is 0, every empty flag is 1, full is 0, the free count equals DEPTH, the overflow and underflow flags are 0 and the enable mask is all zeros.
- R2: A push is accepted when full is low. One cycle later the count of every reader that is enabled both before and after that cycle is one higher. A disabled reader's count stays 0.
- R3: A pull by an enabled reader whose count is nonzero raises that reader's valid output for exactly the next cycle. The data shown is the oldest word that reader has not yet read, so each reader sees words in push order.
- R4: Full is 1 exactly when the largest count among enabled readers equals DEPTH. The free count equals DEPTH minus that largest count. A push while full changes no count and sets the sticky overflow flag.
- R5: A pull by a reader whose count is 0, or whose enable bit is 0, gives no valid output in the next cycle and sets that reader's sticky underflow flag.
- R6: If a reader pulls in the same cycle as an accepted push, its count does not change. If every reader that holds the largest count pulls in that cycle, the free count does not change.
- R7: A configuration write clears mask bits at any time. It sets mask bits only if every enabled reader's count is 0 in that cycle, and otherwise any bit it would set is ignored. The mask is visible on the enable output one cycle later.
- R8: When a reader is disabled, its count goes to 0 in the next cycle and it no longer holds storage, so full and the free count change to reflect the remaining enabled readers.
- R9: A newly enabled reader sees only the words pushed after the cycle of the configuration write, including none pushed in that same cycle.
- R10: Each reader's empty flag is 1 exactly when its count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| push_data_i | input | WIDTH | Word to push |
| full_o | output | 1 | Slowest enabled reader holds DEPTH words |
| free_o | output | $clog2(DEPTH+1) | Free slots |
| overflow_o | output | 1 | Sticky: a push was dropped because the store was full |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mask_i | input | N_CONS | Requested enable mask |
| en_mask_o | output | N_CONS | Current enable mask |
| pop_i | input | N_CONS | Pull request, one bit per reader |
| pop_data_o | output | N_CONS*WIDTH | Pulled word per reader, reader i at bits i*WIDTH |
| pop_valid_o | output | N_CONS | Pulled word valid, one cycle after the pull |
| avail_o | output | N_CONS*$clog2(DEPTH+1) | Unread word count per reader |
| empty_o | output | N_CONS | Reader count is 0 |
| underflow_o | output | N_CONS | Sticky: the reader pulled while its view was empty |

## Verification
Every result is registered once. The counts, the mask, the flags and the valid and data outputs reflect a push, pull or configuration write one clock edge later. Full and the free count are derived from the registered counts and change in that same cycle. The bench drives each stimulus on a falling edge, lets one rising edge pass, and checks on the next falling edge against a model that is updated once per stimulus cycle. A scoreboard queue per reader holds the expected words, and a monitor takes from that queue on every falling edge where that reader's valid output is high.

// File: rtl/mcf_pkg.sv
package mcf_pkg;
    localparam int unsigned MCF_DEF_READERS = 4;
    localparam int unsigned MCF_DEF_DEPTH   = 16;
    localparam int unsigned MCF_DEF_WIDTH   = 32;

    // width of a counter that must hold values 0..depth
    function automatic int unsigned mcf_cnt_w(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction
endpackage

// File: rtl/mcf_store.sv
module mcf_store #(
    parameter int unsigned N_CONS = 4,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WIDTH  = 32,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_i,
    input  logic [WIDTH-1:0]        data_i,
    input  logic                    full_i,
    input  logic [N_CONS*AW-1:0]    rd_addr_i,
    output logic [N_CONS*WIDTH-1:0] rd_word_o,
    output logic [AW-1:0]           wptr_o,
    output logic                    acc_o,
    output logic                    ovf_o
);
    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wptr;
        logic                        ovf;
    } store_st_t;

    store_st_t s_d, s_q;
    logic      accept;

    always_comb begin
        s_d    = s_q;
        accept = push_i && !full_i;
        if (accept) begin
            s_d.mem[s_q.wptr] = data_i;
            s_d.wptr          = s_q.wptr + AW'(1);
        end
        if (push_i && full_i) begin
            s_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < N_CONS; g++) begin : g_rd
        assign rd_word_o[g*WIDTH +: WIDTH] = s_q.mem[rd_addr_i[g*AW +: AW]];
    end

    assign wptr_o = s_q.wptr;
    assign acc_o  = accept;
    assign ovf_o  = s_q.ovf;

    // R4: a push into a full store leaves the write pointer and flags overflow
    assert_full_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_i |=> $stable(wptr_o) && ovf_o);

    // R4: overflow is sticky
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);
endmodule

// File: rtl/mcf_port.sv
module mcf_port #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_cur_i,
    input  logic             en_nxt_i,
    input  logic             wr_acc_i,
    input  logic [AW-1:0]    wptr_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] word_i,
    output logic [AW-1:0]    rd_addr_o,
    output logic [CW-1:0]    avail_o,
    output logic             empty_o,
    output logic [WIDTH-1:0] data_o,
    output logic             valid_o,
    output logic             unf_o
);
    typedef struct packed {
        logic [AW-1:0]    ptr;
        logic [CW-1:0]    avail;
        logic [WIDTH-1:0] data;
        logic             valid;
        logic             unf;
    } port_st_t;

    port_st_t s_d, s_q;
    logic     take;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        take      = pop_i && en_cur_i && (s_q.avail != '0);
        if (pop_i && !take) begin
            s_d.unf = 1'b1;
        end
        if (take) begin
            s_d.data  = word_i;
            s_d.valid = 1'b1;
            s_d.ptr   = s_q.ptr + AW'(1);
        end
        if (!en_cur_i || !en_nxt_i) begin
            // out of the group: follow the writer, hold nothing
            s_d.ptr   = wptr_i + AW'(wr_acc_i);
            s_d.avail = '0;
        end else begin
            s_d.avail = s_q.avail + CW'(wr_acc_i) - CW'(take);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_addr_o = s_q.ptr;
    assign avail_o   = s_q.avail;
    assign empty_o   = (s_q.avail == '0);
    assign data_o    = s_q.data;
    assign valid_o   = s_q.valid;
    assign unf_o     = s_q.unf;

    // R5: pulling an empty view gives no data and flags underflow
    assert_pop_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && (avail_o == '0) |=> unf_o && !valid_o);

    // R3: a legal pull delivers a word next cycle
    assert_pop_delivers_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && en_cur_i && (avail_o != '0) |=> valid_o);

    // R2: the count never exceeds the depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        avail_o <= CW'(DEPTH));

    // R8: leaving the group drops the count to zero
    assert_drop_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_nxt_i |=> avail_o == '0);
endmodule

// File: rtl/mcast_fifo.sv
module mcast_fifo #(
    parameter int unsigned N_CONS = mcf_pkg::MCF_DEF_READERS,
    parameter int unsigned DEPTH  = mcf_pkg::MCF_DEF_DEPTH,
    parameter int unsigned WIDTH  = mcf_pkg::MCF_DEF_WIDTH,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned CW    = mcf_pkg::mcf_cnt_w(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push_i,
    input  logic [WIDTH-1:0]        push_data_i,
    output logic                    full_o,
    output logic [CW-1:0]           free_o,
    output logic                    overflow_o,
    input  logic                    cfg_we_i,
    input  logic [N_CONS-1:0]       cfg_mask_i,
    output logic [N_CONS-1:0]       en_mask_o,
    input  logic [N_CONS-1:0]       pop_i,
    output logic [N_CONS*WIDTH-1:0] pop_data_o,
    output logic [N_CONS-1:0]       pop_valid_o,
    output logic [N_CONS*CW-1:0]    avail_o,
    output logic [N_CONS-1:0]       empty_o,
    output logic [N_CONS-1:0]       underflow_o
);
    typedef struct packed {
        logic [N_CONS-1:0] en;
    } top_st_t;

    top_st_t                 t_d, t_q;
    logic [CW-1:0]           avail_w [N_CONS];
    logic [CW-1:0]           worst;
    logic                    idle;
    logic                    wr_acc;
    logic [AW-1:0]           wptr;
    logic [N_CONS*AW-1:0]    rd_addr;
    logic [N_CONS*WIDTH-1:0] rd_word;

    // slowest enabled reader decides how much is held
    always_comb begin
        worst = '0;
        for (int i = 0; i < N_CONS; i++) begin
            if (t_q.en[i] && (avail_w[i] > worst)) worst = avail_w[i];
        end
    end

    assign idle   = (worst == '0);
    assign full_o = (worst == CW'(DEPTH));
    assign free_o = CW'(DEPTH) - worst;

    always_comb begin
        t_d = t_q;
        if (cfg_we_i) begin
            t_d.en = (t_q.en & cfg_mask_i) | (idle ? cfg_mask_i : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign en_mask_o = t_q.en;

    mcf_store #(.N_CONS(N_CONS), .DEPTH(DEPTH), .WIDTH(WIDTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .data_i    (push_data_i),
        .full_i    (full_o),
        .rd_addr_i (rd_addr),
        .rd_word_o (rd_word),
        .wptr_o    (wptr),
        .acc_o     (wr_acc),
        .ovf_o     (overflow_o)
    );

    for (genvar g = 0; g < N_CONS; g++) begin : g_port
        mcf_port #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_cur_i  (t_q.en[g]),
            .en_nxt_i  (t_d.en[g]),
            .wr_acc_i  (wr_acc),
            .wptr_i    (wptr),
            .pop_i     (pop_i[g]),
            .word_i    (rd_word[g*WIDTH +: WIDTH]),
            .rd_addr_o (rd_addr[g*AW +: AW]),
            .avail_o   (avail_w[g]),
            .empty_o   (empty_o[g]),
            .data_o    (pop_data_o[g*WIDTH +: WIDTH]),
            .valid_o   (pop_valid_o[g]),
            .unf_o     (underflow_o[g])
        );
        assign avail_o[g*CW +: CW] = avail_w[g];
    end

    // R7: no reader joins while any enabled reader still has unread words
    assert_mask_set_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i && !idle |=> (en_mask_o & ~$past(en_mask_o)) == '0);
endmodule

// File: tb/test_mcast_fifo.sv
module test_mcast_fifo;
    localparam int N = 4;
    localparam int D = 16;
    localparam int W = 32;
    localparam int CW = $clog2(D + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            push_i = 1'b0;
    logic [W-1:0]    push_data_i = '0;
    logic            full_o;
    logic [CW-1:0]   free_o;
    logic            overflow_o;
    logic            cfg_we_i = 1'b0;
    logic [N-1:0]    cfg_mask_i = '0;
    logic [N-1:0]    en_mask_o;
    logic [N-1:0]    pop_i = '0;
    logic [N*W-1:0]  pop_data_o;
    logic [N-1:0]    pop_valid_o;
    logic [N*CW-1:0] avail_o;
    logic [N-1:0]    empty_o;
    logic [N-1:0]    underflow_o;

    always #4 clk = ~clk;   // 125 MHz

    mcast_fifo #(.N_CONS(N), .DEPTH(D), .WIDTH(W)) i_mcast_fifo (.*);

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // model
    int           ea [N];
    logic [N-1:0] em = '0;
    logic         eovf = 1'b0;
    logic [N-1:0] eunf = '0;
    logic [N-1:0] evalid = '0;
    logic [W-1:0] sb [N][$];
    logic [W-1:0] word_no = 32'hA000_0000;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_max();
        int m = 0;
        for (int i = 0; i < N; i++) if (em[i] && ea[i] > m) m = ea[i];
        return m;
    endfunction

    task automatic check_all(input string tag);
        int m = model_max();
        chk(tag, "full", int'(full_o), int'(m == D));
        chk(tag, "free", int'(free_o), D - m);
        chk(tag, "overflow", int'(overflow_o), int'(eovf));
        chk(tag, "mask", int'(en_mask_o), int'(em));
        for (int i = 0; i < N; i++) begin
            chk(tag, $sformatf("avail%0d", i), int'(avail_o[i*CW +: CW]), ea[i]);
            chk(tag, $sformatf("empty%0d", i), int'(empty_o[i]), int'(ea[i] == 0));
            chk(tag, $sformatf("valid%0d", i), int'(pop_valid_o[i]), int'(evalid[i]));
            chk(tag, $sformatf("underflow%0d", i), int'(underflow_o[i]), int'(eunf[i]));
        end
    endtask

    // driver: one stimulus cycle, model update, then check on the next falling edge
    task automatic step(input string tag, input logic wr, input logic [N-1:0] rd,
                        input logic cw, input logic [N-1:0] cm);
        int           m;
        logic         acc;
        logic [N-1:0] nm;
        logic [W-1:0] d;
        d = word_no;
        if (wr) word_no = word_no + 1;
        push_i = wr; push_data_i = d; pop_i = rd; cfg_we_i = cw; cfg_mask_i = cm;
        m   = model_max();
        acc = wr && (m != D);
        nm  = cw ? ((em & cm) | ((m == 0) ? cm : '0)) : em;
        if (wr && m == D) eovf = 1'b1;
        for (int i = 0; i < N; i++) begin
            logic take;
            take = rd[i] && em[i] && (ea[i] != 0);
            evalid[i] = take;
            if (rd[i] && !take) eunf[i] = 1'b1;
            if (!em[i] || !nm[i]) begin
                ea[i] = 0;
                sb[i].delete();
            end else begin
                ea[i] = ea[i] + int'(acc) - int'(take);
                if (acc) sb[i].push_back(d);
            end
        end
        em = nm;
        @(posedge clk);
        @(negedge clk);
        push_i = 1'b0; pop_i = '0; cfg_we_i = 1'b0; cfg_mask_i = '0;
        check_all(tag);
    endtask

    // monitor: scoreboard comparison of delivered words (R3)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < N; i++) begin
                if (pop_valid_o[i]) begin
                    checks++;
                    if (sb[i].size() == 0) begin
                        errors++;
                        $display("FAIL R3 reader%0d data: actual %h expected none", i,
                                 pop_data_o[i*W +: W]);
                    end else begin
                        logic [W-1:0] e;
                        e = sb[i].pop_front();
                        if (pop_data_o[i*W +: W] != e) begin
                            errors++;
                            $display("FAIL R3 reader%0d data: actual %h expected %h", i,
                                     pop_data_o[i*W +: W], e);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) ea[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        step("R7", 0, '0, 1, 4'b1011);
        for (int k = 0; k < 3; k++) step("R2", 1, '0, 0, '0);
        check_all("R10");
        step("R7", 0, '0, 1, 4'b1111);            // set while busy: ignored
        step("R5", 0, 4'b0100, 0, '0);            // disabled reader pulls
        for (int k = 0; k < 3; k++) step("R3", 0, 4'b0001, 0, '0);
        step("R6", 1, 4'b1010, 0, '0);            // push with pulls by the slowest
        for (int k = 0; k < 20; k++) step("R4", 1, '0, 0, '0);
        for (int k = 0; k < 16; k++) step("R4", 0, 4'b0011, 0, '0);
        step("R8", 0, '0, 1, 4'b0011);            // drop reader 3
        step("R5", 0, 4'b0001, 0, '0);
        step("R9", 1, '0, 1, 4'b1111);            // join and push same cycle
        step("R9", 1, '0, 0, '0);
        step("R9", 1, '0, 0, '0);
        for (int k = 0; k < 4; k++) step("R9", 0, 4'b1111, 0, '0);
        for (int i = 0; i < N; i++) chk("R3", $sformatf("scoreboard%0d left", i), sb[i].size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule